// File: doc/BRIEF.md
# Shared-Inverse AES Byte Substitution Unit

This unit substitutes one byte per clock, in either the forward AES direction or the inverse one. A single direction input picks which. Both directions run through the same GF(2^8) multiplicative-inverse core. Only the affine map and its inverse are built twice. The affine map sits after the core for encryption. The inverse affine map sits before the core for decryption. Two direction-controlled multiplexers route the byte around the core.

The core has two build-time forms. One is a 256-entry lookup table whose contents are computed during elaboration. The other computes the inverse as a chain of squarings and multiplications. A second parameter adds an output register. To cover a full 128-bit state, sixteen instances are placed side by side. Key expansion and the other round steps are outside this block.

Top module: `aes_shared_sbox`

## Requirements
- R1: With `dec_sel` low, the result is A(inv(din)). Here inv is the multiplicative inverse modulo x^8+x^4+x^3+x+1 (0x11B). A sets output bit i to a[i]^a[i+4]^a[i+5]^a[i+6]^a[i+7]^c[i], with indices taken mod 8 and c = 0x63. For example, 0x53 maps to 0xED.
- R2: With `dec_sel` high, the result is inv(B(din)). B sets output bit i to a[(i+2)%8]^a[(i+5)%8]^a[(i+7)%8]^d[i], with d = 0x05. For example, 0xED maps to 0x53.
- R3: The inverse of 0x00 is taken as 0x00. So forward 0x00 gives 0x63, and inverse 0x63 gives 0x00.
- R4: For every nonzero byte entering the shared inverse core, the core output multiplied by that byte in GF(2^8) equals 0x01. The core output is never zero for a nonzero input.
- R5: Feeding the forward result of any byte back in with `dec_sel` high returns the original byte, for all 256 values.
- R6: With `OUT_REG` = 1, `dout` changes only at a rising clock edge and carries the result for the `din`/`dec_sel` sampled at that edge. With `OUT_REG` = 0, `dout` follows the inputs combinationally.
- R7: With `OUT_REG` = 1, `dout` is 0x00 while `rst_n` is low (asynchronous, active-low reset).
- R8: The direction may change on every clock with no idle cycle. Each result uses the direction sampled together with its own data byte.
- R9: Both core forms (`USE_TABLE` = 1 or 0) give identical results for every input in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge (used only when `OUT_REG` = 1) |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| dec_sel | input | 1 | Direction: 0 = forward substitution, 1 = inverse substitution |
| din | input | 8 | Byte to substitute |
| dout | output | 8 | Substituted byte |

## Verification
The hardest case to reach from the ports is the shared core seeing the same byte from both directions in back-to-back cycles, while the direction select flips on every clock. This is where a wrongly steered input or output multiplexer would show. The bench streams bytes with the direction alternating each cycle. It chooses each decrypt input as the affine image of the byte it follows, so the core input stays the same across the flip. It also sweeps all 256 bytes both ways, and feeds every forward result from the design back in to close the round trip.

// File: rtl/aes_sbox_pkg.sv
package aes_sbox_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FWD_AFF_C = 8'h63;
  localparam logic [BYTE_W-1:0] INV_AFF_C = 8'h05;
  localparam logic [BYTE_W-1:0] RED_POLY  = 8'h1B; // x^8 folded back: x^4+x^3+x+1

  typedef logic [BYTE_W-1:0] byte_t;

  // Multiply by x with reduction
  function automatic byte_t gf_xtime(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? RED_POLY : 8'h00);
  endfunction

  // Field multiply, shift-and-add
  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc = '0;
    byte_t sh  = a;
    for (int k = 0; k < BYTE_W; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  function automatic byte_t gf_sq(byte_t a);
    return gf_mul(a, a);
  endfunction

  // a^254 via an addition chain; 0 maps to 0 naturally
  function automatic byte_t gf_inv_chain(byte_t a);
    byte_t p3, p7, p15, p31, p63, p127;
    p3   = gf_mul(gf_sq(a), a);
    p7   = gf_mul(gf_sq(p3), a);
    p15  = gf_mul(gf_sq(p7), a);
    p31  = gf_mul(gf_sq(p15), a);
    p63  = gf_mul(gf_sq(p31), a);
    p127 = gf_mul(gf_sq(p63), a);
    return gf_sq(p127);
  endfunction

  function automatic byte_t rotl8(byte_t a, int unsigned n);
    return byte_t'((a << n) | (a >> (BYTE_W - n)));
  endfunction

  // Forward affine: circulant sum of rotations 0..4 plus constant
  function automatic byte_t aff_fwd(byte_t a);
    return a ^ rotl8(a, 1) ^ rotl8(a, 2) ^ rotl8(a, 3) ^ rotl8(a, 4) ^ FWD_AFF_C;
  endfunction

  // Inverse affine: rotations 1, 3, 6 plus constant
  function automatic byte_t aff_inv(byte_t a);
    return rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ INV_AFF_C;
  endfunction

endpackage

// File: rtl/sbox_gf_inv.sv
module sbox_gf_inv
  import aes_sbox_pkg::*;
#(
  parameter bit USE_TABLE = 1'b1
) (
  input  logic [BYTE_W-1:0] a,
  output logic [BYTE_W-1:0] y
);

  localparam int N_ENTRIES = 1 << BYTE_W;

  generate
    if (USE_TABLE) begin : g_table
      byte_t inv_rom [N_ENTRIES];
      for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_fill
        assign inv_rom[gi] = gf_inv_chain(byte_t'(gi));
      end
      assign y = inv_rom[a];
    end else begin : g_chain
      assign y = gf_inv_chain(a);
    end
  endgenerate

endmodule

// File: rtl/sbox_affine.sv
module sbox_affine
  import aes_sbox_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic [BYTE_W-1:0] a,
  output logic [BYTE_W-1:0] y
);

  generate
    if (INVERSE) begin : g_inv
      assign y = aff_inv(a);
    end else begin : g_fwd
      assign y = aff_fwd(a);
    end
  endgenerate

endmodule

// File: rtl/aes_shared_sbox.sv
module aes_shared_sbox
  import aes_sbox_pkg::*;
#(
  parameter bit USE_TABLE = 1'b1,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dec_sel,
  input  logic [7:0]  din,
  output logic [7:0]  dout
);

  // Named internal nets, visible to the bound checker
  byte_t pre_aff;   // inverse affine of din (decrypt entry)
  byte_t inv_in;    // operand of the shared inverse core
  byte_t inv_out;   // result of the shared inverse core
  byte_t post_aff;  // forward affine of inv_out (encrypt exit)
  byte_t sub_res;   // combinational substitution result

  sbox_affine #(.INVERSE(1'b1)) u_pre_aff (
    .a (din),
    .y (pre_aff)
  );

  // Entry multiplexer
  assign inv_in = dec_sel ? pre_aff : din;

  sbox_gf_inv #(.USE_TABLE(USE_TABLE)) u_core (
    .a (inv_in),
    .y (inv_out)
  );

  sbox_affine #(.INVERSE(1'b0)) u_post_aff (
    .a (inv_out),
    .y (post_aff)
  );

  // Exit multiplexer
  assign sub_res = dec_sel ? inv_out : post_aff;

  generate
    if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else        dout <= sub_res;
      end
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign dout = sub_res;
    end
  endgenerate

endmodule

// File: rtl/sbox_checker.sv
module sbox_checker
  import aes_sbox_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        dec_sel,
  input logic [7:0]  din,
  input logic [7:0]  dout,
  input logic [7:0]  inv_in,
  input logic [7:0]  inv_out
);

  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  AST_CORE_PRODUCT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_in != 8'h00) |-> (gf_mul(inv_in, inv_out) == 8'h01)); // R4

  AST_CORE_ZERO_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_in == 8'h00) |-> (inv_out == 8'h00)); // R3

  generate
    if (OUT_REG) begin : g_reg_chk
      AST_ENC_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(dec_sel)) |->
          (($past(din) == 8'h00) ? (aff_inv(dout) == 8'h00)
                                 : (gf_mul(aff_inv(dout), $past(din)) == 8'h01))); // R1

      AST_DEC_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(dec_sel)) |->
          ((aff_inv($past(din)) == 8'h00) ? (dout == 8'h00)
                                          : (gf_mul(dout, aff_inv($past(din))) == 8'h01))); // R2
    end else begin : g_comb_chk
      AST_ENC_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_sel |->
          ((din == 8'h00) ? (aff_inv(dout) == 8'h00)
                          : (gf_mul(aff_inv(dout), din) == 8'h01))); // R1

      AST_DEC_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_sel |->
          ((aff_inv(din) == 8'h00) ? (dout == 8'h00)
                                   : (gf_mul(dout, aff_inv(din)) == 8'h01))); // R2
    end
  endgenerate

endmodule

bind aes_shared_sbox sbox_checker #(.OUT_REG(OUT_REG)) u_sbox_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .dec_sel (dec_sel),
  .din     (din),
  .dout    (dout),
  .inv_in  (inv_in),
  .inv_out (inv_out)
);

// File: tb/test_aes_shared_sbox.sv
module test_aes_shared_sbox;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_sel = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic [7:0] dout_alt;

  int n_vec  = 0;
  int n_fail = 0;

  logic [7:0] ref_fwd [256];
  logic [7:0] ref_inv [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_shared_sbox #(.USE_TABLE(1'b1), .OUT_REG(1'b1)) i_aes_shared_sbox (
    .clk (clk), .rst_n (rst_n), .dec_sel (dec_sel), .din (din), .dout (dout)
  );

  aes_shared_sbox #(.USE_TABLE(1'b0), .OUT_REG(1'b0)) i_aes_shared_sbox_alt (
    .clk (clk), .rst_n (rst_n), .dec_sel (dec_sel), .din (din), .dout (dout_alt)
  );

  // Reference arithmetic written independently: Russian-peasant multiply,
  // brute-force inverse search, bitwise affine maps.
  function automatic logic [7:0] t_mul(logic [7:0] a, logic [7:0] b);
    logic [15:0] prod = '0;
    for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h011B << (i - 8));
    return prod[7:0];
  endfunction

  function automatic logic [7:0] t_inv(logic [7:0] a);
    logic [7:0] r = 8'h00;
    for (int c = 1; c < 256; c++) if (t_mul(a, 8'(c)) == 8'h01) r = 8'(c);
    return r;
  endfunction

  function automatic logic [7:0] t_aff(logic [7:0] a);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] t_iaff(logic [7:0] a);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = a[(i+2)%8] ^ a[(i+5)%8] ^ a[(i+7)%8] ^ (8'h05 >> i) & 1'b1;
    return r;
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  // Drive at a falling edge, check the combinational alternate at once,
  // check that the registered output has not moved, then read it one
  // falling edge later (one rising edge in between).
  task automatic apply(logic dir, logic [7:0] val, output logic [7:0] reg_out);
    logic [7:0] held;
    @(negedge clk);
    held = dout;
    dec_sel = dir;
    din = val;
    #1;
    check("R9", dout_alt, dir ? ref_inv[val] : ref_fwd[val]);
    check("R6", dout, held);
    @(negedge clk);
    reg_out = dout;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] y, z;
    logic [7:0] prev_exp;
    for (int x = 0; x < 256; x++) begin
      ref_fwd[x] = t_aff(t_inv(8'(x)));
      ref_inv[x] = t_inv(t_iaff(8'(x)));
    end

    // R7: reset holds output at zero
    din = 8'h53;
    repeat (3) @(negedge clk);
    check("R7", dout, 8'h00);
    rst_n = 1'b1;

    // Known points: R1, R2, R3
    apply(1'b0, 8'h53, y); check("R1", y, 8'hED);
    apply(1'b1, 8'hED, y); check("R2", y, 8'h53);
    apply(1'b0, 8'h00, y); check("R3", y, 8'h63);
    apply(1'b1, 8'h63, y); check("R3", y, 8'h00);

    // Exhaustive forward with round trip through the design (R1, R4, R5)
    for (int x = 0; x < 256; x++) begin
      apply(1'b0, 8'(x), y);
      check("R1", y, ref_fwd[x]);
      check("R4", t_mul(t_iaff(y), 8'(x)), (x == 0) ? 8'h00 : 8'h01);
      apply(1'b1, y, z);
      check("R5", z, 8'(x));
    end

    // Exhaustive inverse direction (R2)
    for (int x = 0; x < 256; x++) begin
      apply(1'b1, 8'(x), y);
      check("R2", y, ref_inv[x]);
    end

    // R8: direction flips every cycle, streamed with no gap; each decrypt
    // byte is the affine image of the preceding encrypt byte so the core
    // sees the same operand across the flip.
    @(negedge clk);
    dec_sel = 1'b0; din = 8'h00; prev_exp = ref_fwd[0];
    for (int k = 1; k < 200; k++) begin
      logic [7:0] nv;
      logic       nd;
      @(negedge clk);
      check("R8", dout, prev_exp);
      nd = k[0];
      nv = nd ? t_aff(8'((k * 37) & 8'hFF)) : 8'((k * 37 + 11) & 8'hFF);
      if (nd) nv = t_aff(din);
      dec_sel = nd;
      din = nv;
      prev_exp = nd ? ref_inv[nv] : ref_fwd[nv];
    end
    @(negedge clk);
    check("R8", dout, prev_exp);

    // R7 again: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1 check("R7", dout, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    finish_run();
  end

endmodule